// File: doc/BRIEF.md
# Landing Pad Control-Flow Guard

This block enforces forward-edge control-flow integrity beside a processor's retire stage. Each retired instruction is presented with a class code, its source register index, its program counter, the label carried in the instruction and the upper twenty bits of general register x7. An indirect jump-and-link retired while protection is enabled arms an "expect a landing pad" flag, unless its source register is one of the untracked registers (x1 and x5 for returns, x7 for software-guarded branches).

The instruction that retires next must be a landing pad. A pad that arrives with the flag armed disarms it and is checked in two steps. The first step is that its address must be word aligned. The second step applies only when its label is nonzero: that label must equal bits 31:12 of x7. If either step fails, or if some other instruction retires while the flag is armed, the block raises a one-cycle software-check exception request and presents a fixed cause code as the trap value. A landing pad that retires while the flag is clear has no effect. Trap entry and synchronous reset both clear the flag.

Top module: `lpad_cfi_guard`

## Requirements
- R1: After synchronous reset, expectPad, excReq and excValue are all 0.
- R2: A retired instruction with class 2'b01 (indirect jump) while cfiEnable is 1 and srcReg is not 1, 5 or 7 makes expectPad 1 from the next cycle.
- R3: An indirect jump whose srcReg is 1, 5 or 7 leaves expectPad at 0.
- R4: While cfiEnable is 0 an indirect jump never sets expectPad.
- R5: A retired landing pad (class 2'b10) while expectPad is 0 raises nothing and leaves expectPad at 0.
- R6: A landing pad retired while expectPad is 1 clears expectPad in the next cycle, and a passing pad raises no exception.
- R7: A landing pad retired with expectPad 1 and pc[1:0] nonzero raises excReq for exactly one cycle (the cycle after retire), with excValue equal to CAUSE_VAL (default 2); excValue is 0 whenever excReq is 0.
- R8: With expectPad 1 and padLabel nonzero, a pad whose padLabel differs from x7Upper raises the exception, and a pad whose padLabel equals x7Upper does not.
- R9: With padLabel equal to 0 the label is not compared: an aligned pad passes whatever x7Upper holds.
- R10: Alignment is checked before the label, and a pad that fails both checks raises one single-cycle exception request.
- R11: Any retired instruction other than a landing pad (class 2'b00, 2'b01 or 2'b11) while expectPad is 1 raises the exception and clears expectPad.
- R12: trapEntry clears expectPad in the next cycle, taking priority over a concurrent arming jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retireValid | input | 1 | An instruction retires this cycle |
| instClass | input | 2 | 00 other, 01 indirect jump-and-link, 10 landing pad, 11 other |
| srcReg | input | 5 | Source register index of the retiring jump |
| pc | input | XLEN | Address of the retiring instruction |
| padLabel | input | 20 | Label embedded in the landing pad |
| x7Upper | input | 20 | Bits 31:12 of register x7 |
| cfiEnable | input | 1 | Forward-edge protection enabled |
| trapEntry | input | 1 | A trap is being taken; disarms the flag |
| expectPad | output | 1 | Landing pad expected next |
| excReq | output | 1 | Software-check exception request, one cycle |
| excValue | output | XLEN | Trap value, CAUSE_VAL while excReq is 1, else 0 |

## Verification
The assertions assume that each retire strobe lasts a single clock and that the inputs are stable around the sampling edge. They also assume that the flag's only routes to 1 are arming jumps, so any exception must follow a cycle with both the flag and a retire present. The stimulus drives every input on the falling edge and holds a retire for one cycle before it idles the strobe. It always reasserts protection, or pulses trapEntry, before it arms the flag again, so the sequences stay inside what the properties expect.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_IJUMP = 2'b01,
    CLS_PAD   = 2'b10,
    CLS_RSVD  = 2'b11
  } instClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic raise;
  } ctlStrobes_t;

  localparam int NUM_EXEMPT = 3;
  localparam logic [4:0] EXEMPT_REGS [NUM_EXEMPT] = '{5'd1, 5'd5, 5'd7};
endpackage

// File: rtl/lpad_ctl.sv
module lpad_ctl
  import lpad_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 retireValid,
  input  logic [1:0]           instClass,
  input  logic [REG_IDX_W-1:0] srcReg,
  input  logic                 cfiEnable,
  input  logic                 trapEntry,
  input  logic                 padFault,
  output ctlStrobes_t          strobes,
  output logic                 expectPad
);
  instClass_e cls;
  logic [NUM_EXEMPT-1:0] exemptHit;
  logic isExempt;
  logic flagQ;

  assign cls = instClass_e'(instClass);

  for (genvar i = 0; i < NUM_EXEMPT; i++) begin : g_exempt
    assign exemptHit[i] = (srcReg == REG_IDX_W'(EXEMPT_REGS[i]));
  end
  assign isExempt = |exemptHit;

  always_comb begin
    strobes = '0;
    if (retireValid) begin
      if (flagQ) begin
        strobes.clrFlag = 1'b1;
        if (cls != CLS_PAD) strobes.raise = 1'b1;
        else if (padFault)  strobes.raise = 1'b1;
      end else if (cls == CLS_IJUMP && cfiEnable && !isExempt) begin
        strobes.setFlag = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || trapEntry)     flagQ <= 1'b0;
    else if (strobes.clrFlag) flagQ <= 1'b0;
    else if (strobes.setFlag) flagQ <= 1'b1;
  end

  assign expectPad = flagQ;
endmodule

// File: rtl/lpad_dp.sv
module lpad_dp
  import lpad_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LABEL_W   = 20,
  parameter int CAUSE_VAL = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    pc,
  input  logic [LABEL_W-1:0] padLabel,
  input  logic [LABEL_W-1:0] x7Upper,
  input  ctlStrobes_t        strobes,
  output logic               padFault,
  output logic               excReq,
  output logic [XLEN-1:0]    excValue
);
  localparam logic [XLEN-1:0] CAUSE_WORD = XLEN'(CAUSE_VAL);
  logic misaligned;
  logic labelBad;

  assign misaligned = |pc[1:0];
  // label consulted only for an aligned pad with a nonzero label
  assign labelBad   = !misaligned && (padLabel != '0) && (padLabel != x7Upper);
  assign padFault   = misaligned || labelBad;

  always_ff @(posedge clk) begin
    if (rst) begin
      excReq   <= 1'b0;
      excValue <= '0;
    end else begin
      excReq   <= strobes.raise;
      excValue <= strobes.raise ? CAUSE_WORD : '0;
    end
  end
endmodule

// File: rtl/lpad_cfi_guard.sv
module lpad_cfi_guard
  import lpad_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LABEL_W   = 20,
  parameter int REG_IDX_W = 5,
  parameter int CAUSE_VAL = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 retireValid,
  input  logic [1:0]           instClass,
  input  logic [REG_IDX_W-1:0] srcReg,
  input  logic [XLEN-1:0]      pc,
  input  logic [LABEL_W-1:0]   padLabel,
  input  logic [LABEL_W-1:0]   x7Upper,
  input  logic                 cfiEnable,
  input  logic                 trapEntry,
  output logic                 expectPad,
  output logic                 excReq,
  output logic [XLEN-1:0]      excValue
);
  ctlStrobes_t strobes;
  logic padFault;

  lpad_ctl #(.REG_IDX_W(REG_IDX_W)) u_ctl (
    .clk(clk), .rst(rst), .retireValid(retireValid), .instClass(instClass),
    .srcReg(srcReg), .cfiEnable(cfiEnable), .trapEntry(trapEntry),
    .padFault(padFault), .strobes(strobes), .expectPad(expectPad)
  );

  lpad_dp #(.XLEN(XLEN), .LABEL_W(LABEL_W), .CAUSE_VAL(CAUSE_VAL)) u_dp (
    .clk(clk), .rst(rst), .pc(pc), .padLabel(padLabel), .x7Upper(x7Upper),
    .strobes(strobes), .padFault(padFault), .excReq(excReq), .excValue(excValue)
  );
endmodule

// File: rtl/lpad_cfi_chk.sv
module lpad_cfi_chk #(
  parameter int XLEN      = 32,
  parameter int CAUSE_VAL = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            retireValid,
  input logic [1:0]      instClass,
  input logic            cfiEnable,
  input logic            trapEntry,
  input logic            expectPad,
  input logic            excReq,
  input logic [XLEN-1:0] excValue
);
  // R4
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(expectPad) |-> $past(cfiEnable));
  // R7
  cause_value_chk: assert property (@(posedge clk) disable iff (rst)
    excReq |-> excValue == XLEN'(CAUSE_VAL));
  // R7
  quiet_value_chk: assert property (@(posedge clk) disable iff (rst)
    !excReq |-> excValue == '0);
  // R5
  exc_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    excReq |-> ($past(expectPad) && $past(retireValid)));
  // R6
  pad_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    (retireValid && instClass == 2'b10 && expectPad) |=> !expectPad);
  // R12
  trap_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    trapEntry |=> !expectPad);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    excReq |=> !excReq);
endmodule

bind lpad_cfi_guard lpad_cfi_chk #(.XLEN(XLEN), .CAUSE_VAL(CAUSE_VAL)) u_chk (
  .clk(clk), .rst(rst), .retireValid(retireValid), .instClass(instClass),
  .cfiEnable(cfiEnable), .trapEntry(trapEntry), .expectPad(expectPad),
  .excReq(excReq), .excValue(excValue)
);

// File: tb/sim_lpad_cfi_guard.sv
`timescale 1ns/1ps
module sim_lpad_cfi_guard;
  logic clk = 1'b0;
  logic rst, retireValid, cfiEnable, trapEntry;
  logic [1:0] instClass;
  logic [4:0] srcReg;
  logic [31:0] pc;
  logic [19:0] padLabel, x7Upper;
  logic expectPad, excReq;
  logic [31:0] excValue;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpad_cfi_guard u0 (
    .clk(clk), .rst(rst), .retireValid(retireValid), .instClass(instClass),
    .srcReg(srcReg), .pc(pc), .padLabel(padLabel), .x7Upper(x7Upper),
    .cfiEnable(cfiEnable), .trapEntry(trapEntry), .expectPad(expectPad),
    .excReq(excReq), .excValue(excValue)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one retire on the falling edge, sample 1 ns after the rising edge
  task automatic retire(logic [1:0] c, logic [4:0] s, logic [31:0] a,
                        logic [19:0] lab, logic [19:0] x7, logic en, logic trap);
    @(negedge clk);
    retireValid = 1'b1; instClass = c; srcReg = s; pc = a;
    padLabel = lab; x7Upper = x7; cfiEnable = en; trapEntry = trap;
    @(posedge clk); #1;
    retireValid = 1'b0; trapEntry = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    retireValid = 1'b0; trapEntry = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic arm();
    retire(2'b01, 5'd10, 32'h100, 20'h0, 20'h0, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 flag", expectPad, 0); chk("R1 exc", excReq, 0); chk("R1 val", excValue, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_arm();
    arm(); chk("R2 armed", expectPad, 1); chk("R2 noexc", excReq, 0);
    retire(2'b10, 5'd0, 32'h200, 20'h0, 20'h0, 1'b1, 1'b0);
    chk("R6 cleared", expectPad, 0); chk("R6 passnoexc", excReq, 0);
  endtask

  task automatic t_exempt();
    for (int i = 0; i < 3; i++) begin
      logic [4:0] r;
      r = (i == 0) ? 5'd1 : (i == 1) ? 5'd5 : 5'd7;
      retire(2'b01, r, 32'h100, 20'h0, 20'h0, 1'b1, 1'b0);
      chk("R3 exempt", expectPad, 0);
    end
    retire(2'b01, 5'd6, 32'h100, 20'h0, 20'h0, 1'b0, 1'b0);
    chk("R4 disabled", expectPad, 0);
  endtask

  task automatic t_stray_pad();
    retire(2'b10, 5'd0, 32'h202, 20'h5, 20'h9, 1'b1, 1'b0);
    chk("R5 noexc", excReq, 0); chk("R5 flag", expectPad, 0);
    idle(); chk("R5 later", excReq, 0);
  endtask

  task automatic t_misaligned();
    arm();
    retire(2'b10, 5'd0, 32'h202, 20'h0, 20'h0, 1'b1, 1'b0);
    chk("R7 exc", excReq, 1); chk("R7 val", excValue, 2); chk("R7 flag", expectPad, 0);
    idle(); chk("R7 pulse", excReq, 0); chk("R7 valzero", excValue, 0);
  endtask

  task automatic t_label();
    arm();
    retire(2'b10, 5'd0, 32'h300, 20'hABCDE, 20'hABCDF, 1'b1, 1'b0);
    chk("R8 mismatch", excReq, 1);
    arm();
    retire(2'b10, 5'd0, 32'h300, 20'hABCDE, 20'hABCDE, 1'b1, 1'b0);
    chk("R8 match", excReq, 0); chk("R8 flag", expectPad, 0);
    arm();
    retire(2'b10, 5'd0, 32'h300, 20'h0, 20'h12345, 1'b1, 1'b0);
    chk("R9 zerolabel", excReq, 0);
  endtask

  task automatic t_both();
    arm();
    retire(2'b10, 5'd0, 32'h301, 20'h1, 20'h2, 1'b1, 1'b0);
    chk("R10 exc", excReq, 1);
    idle(); chk("R10 single", excReq, 0);
  endtask

  task automatic t_other();
    arm();
    retire(2'b00, 5'd3, 32'h400, 20'h0, 20'h0, 1'b1, 1'b0);
    chk("R11 exc", excReq, 1); chk("R11 flag", expectPad, 0);
    arm();
    retire(2'b11, 5'd3, 32'h400, 20'h0, 20'h0, 1'b1, 1'b0);
    chk("R11 rsvd", excReq, 1);
  endtask

  task automatic t_trap();
    arm();
    @(negedge clk); trapEntry = 1'b1;
    @(posedge clk); #1; trapEntry = 1'b0;
    chk("R12 trapclr", expectPad, 0);
    retire(2'b01, 5'd10, 32'h100, 20'h0, 20'h0, 1'b1, 1'b1);
    chk("R12 priority", expectPad, 0);
    arm(); t_reset(); chk("R12 rstclr", expectPad, 0);
  endtask

  initial begin
    rst = 1'b1; retireValid = 1'b0; instClass = 2'b00; srcReg = '0; pc = '0;
    padLabel = '0; x7Upper = '0; cfiEnable = 1'b0; trapEntry = 1'b0;
    t_reset();
    t_arm(); t_exempt(); t_stray_pad(); t_misaligned();
    t_label(); t_both(); t_other(); t_trap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule